// File: doc/BRIEF.md
# Strap-Addressed I2C Register Target

This block is an I2C target that lets a host read and write a sixteen-entry file of 8-bit registers. SCL and SDA arrive as raw bus levels. Each line passes through a two-flop synchronizer and a glitch filter clocked by the system clock. The filtered lines are then checked for START, repeated START and STOP conditions and for SCL edges. The block drives SDA only through an open-drain enable: `sda_oe` high pulls the line low, and the block never drives a high level.

The 7-bit device address is not programmable. A 3-bit strap code, which stands in for an external resistor setting, selects it from a fixed table. Code 0 means the strap pin is tied straight to ground, and that setting is never a valid address. After reset the target stays silent for a power-up interval of `PWRUP_CYC` system clocks. The default is 1,000,000 clocks, which is 10 ms at 100 MHz.

The control state machine has the following states:
- `ST_LOCK`: the power-up hold.
- `ST_IDLE`: waiting for a START.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: the acknowledge slot after the address.
- `ST_WR_BYTE` and `ST_WR_ACK`: receiving a byte, then acknowledging it.
- `ST_RD_BYTE`: driving a byte out.
- `ST_RD_ACK`: sampling the host's response after a read byte.
- `ST_WAIT_STOP`: ignoring the bus until the next START.

Transitions:
- `ST_LOCK` goes to `ST_IDLE` when the interval ends.
- From any state other than `ST_LOCK`, a START goes to `ST_ADDR` and a STOP goes to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on a match and to `ST_WAIT_STOP` on a mismatch.
- `ST_ADDR_ACK` goes to `ST_WR_BYTE` for R/W=0 and to `ST_RD_BYTE` for R/W=1.
- `ST_WR_BYTE` and `ST_WR_ACK` alternate.
- `ST_RD_BYTE` goes to `ST_RD_ACK`.
- `ST_RD_ACK` goes back to `ST_RD_BYTE` on a host ACK and to `ST_WAIT_STOP` on a host NACK.

Top module: `strap_i2c_target`

## Requirements
- R1: `strap_code` selects the 7-bit device address as follows: 1 gives 0x71, 2 gives 0x72, 3 gives 0x73 and 4 gives 0x76. The R/W flag is bit 0 of the address byte, and 0 means write.
- R2: With `strap_code` set to 0 (pin grounded) or to 5, 6 or 7, the target never acknowledges any address and never pulls SDA low.
- R3: A falling SDA while SCL is high is a START or repeated START. A rising SDA while SCL is high is a STOP, and a STOP returns the target to idle.
- R4: In the ninth clock after the address byte, the target pulls SDA low only if the address matches. On a mismatch it leaves SDA released and ignores all further bytes until the next START, and no register changes.
- R5: In a write, the first byte after the address sets the register pointer from its low 4 bits. Every later byte is stored at the pointer, and the target acknowledges every byte it receives.
- R6: A read is a pointer write followed by a repeated START and the address with R/W=1. The target then drives the register at the pointer, MSB first.
- R7: During a read, a host ACK after a byte makes the target send the next register. A host NACK makes it release SDA and wait for a STOP.
- R8: The register pointer increments after every data byte, whether written or read, and wraps from 15 to 0.
- R9: For `PWRUP_CYC` clocks after reset the target ignores the bus and never pulls SDA low.
- R10: A START or STOP in the middle of a byte aborts that byte. Nothing is written, and a START restarts address reception.
- R11: After reset every register reads 0 and `sda_oe` is low. `sda_oe` changes only after an SCL falling edge, a START or a STOP, so SDA stays stable while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_code | input | 3 | Address strap setting (0 = grounded, invalid) |
| scl_i | input | 1 | Raw SCL bus level |
| sda_i | input | 1 | Raw SDA bus level |
| sda_oe | output | 1 | Open-drain enable; high pulls SDA low |

## Verification
The bench sets `PWRUP_CYC` to 2000 clocks. This is short enough that the lockout can be tested and then left behind within a few thousand cycles, yet long enough that a complete address byte falls inside it. `FILT_LEN` stays at 3, and each SCL phase lasts ten clocks, so the filter delay fits inside a phase with margin. With `REGS` at 16 the 4-bit pointer wraps after a short burst, which brings the 15-to-0 rollover within reach.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [3:0] {
        ST_LOCK,
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_WAIT_STOP
    } tgt_state_e;

    typedef struct packed {
        logic       ok;
        logic [6:0] addr;
    } strap_addr_t;

    // Strap table: code 0 is a grounded pin, codes above 4 are unused.
    function automatic strap_addr_t strap_decode(input logic [2:0] code);
        strap_addr_t r;
        case (code)
            3'd1:    r = '{ok: 1'b1, addr: 7'h71};
            3'd2:    r = '{ok: 1'b1, addr: 7'h72};
            3'd3:    r = '{ok: 1'b1, addr: 7'h73};
            3'd4:    r = '{ok: 1'b1, addr: 7'h76};
            default: r = '{ok: 1'b0, addr: 7'h00};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;
    logic          out_q;

    // The filtered level changes only after the synchronized input holds a new value for FILT_LEN clocks.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            run_q  <= '0;
            out_q  <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], din};
            if (sync_q[1] != out_q) begin
                if (run_q == CW'(FILT_LEN - 1)) begin
                    out_q <= sync_q[1];
                    run_q <= '0;
                end else begin
                    run_q <= run_q + CW'(1);
                end
            end else begin
                run_q <= '0;
            end
        end
    end

    assign dout = out_q;
endmodule

// File: rtl/i2c_regfile.sv
module i2c_regfile #(
    parameter int REGS = 16,
    parameter int DW   = 8,
    parameter int AW   = $clog2(REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [REGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < REGS; i++) mem[i] <= '0;
        end else begin
            for (int i = 0; i < REGS; i++)
                if (we && waddr == AW'(i)) mem[i] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter int PWRUP_CYC = 1000000,
    parameter int REGS      = 16,
    parameter int AW        = $clog2(REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_f,
    input  logic          sda_f,
    input  logic [6:0]    dev_addr,
    input  logic          addr_ok,
    input  logic [7:0]    rd_data,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [7:0]    wdata,
    output logic [AW-1:0] raddr,
    output logic          sda_oe
);
    localparam int PW = $clog2(PWRUP_CYC + 1);

    tgt_state_e    state_q, state_d;
    logic          scl_q, sda_q;
    logic [PW-1:0] pwr_cnt;
    logic [2:0]    bit_q;
    logic [7:0]    sh_q;
    logic          ack_on_q, rw_q, ptr_ph_q, more_q;
    logic [AW-1:0] ptr_q;

    logic start_c, stop_c, rise_c, fall_c, pwr_done;
    logic [7:0] sh_in;

    assign start_c  = scl_f && scl_q && sda_q && !sda_f;
    assign stop_c   = scl_f && scl_q && !sda_q && sda_f;
    assign rise_c   = scl_f && !scl_q;
    assign fall_c   = !scl_f && scl_q;
    assign pwr_done = (pwr_cnt == PW'(PWRUP_CYC));
    assign sh_in    = {sh_q[6:0], sda_f};
    assign raddr    = ptr_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (state_q == ST_LOCK) begin
            if (pwr_done) state_d = ST_IDLE;
        end else if (start_c) begin
            state_d = ST_ADDR;
        end else if (stop_c) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_ADDR:     if (rise_c && bit_q == 3'd7)
                                 state_d = (addr_ok && sh_in[7:1] == dev_addr) ? ST_ADDR_ACK : ST_WAIT_STOP;
                ST_ADDR_ACK: if (fall_c && ack_on_q) state_d = rw_q ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (rise_c && bit_q == 3'd7) state_d = ST_WR_ACK;
                ST_WR_ACK:   if (fall_c && ack_on_q) state_d = ST_WR_BYTE;
                ST_RD_BYTE:  if (fall_c && bit_q == 3'd7) state_d = ST_RD_ACK;
                ST_RD_ACK:   if (fall_c) state_d = more_q ? ST_RD_BYTE : ST_WAIT_STOP;
                default: ;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOCK;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;  sda_q <= 1'b1;
            pwr_cnt <= '0;  bit_q <= '0;   sh_q <= '0;
            ack_on_q <= 1'b0; rw_q <= 1'b0; ptr_ph_q <= 1'b0; more_q <= 1'b0;
            ptr_q <= '0;    we <= 1'b0;    waddr <= '0;  wdata <= '0;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
            we    <= 1'b0;
            if (!pwr_done) pwr_cnt <= pwr_cnt + PW'(1);
            if (state_q != ST_LOCK && (start_c || stop_c)) begin
                bit_q    <= '0;
                ack_on_q <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_ADDR: if (rise_c) begin
                        sh_q  <= sh_in;
                        bit_q <= bit_q + 3'd1;
                        if (bit_q == 3'd7) rw_q <= sda_f;
                    end
                    ST_ADDR_ACK, ST_WR_ACK: if (fall_c) begin
                        if (!ack_on_q) begin
                            ack_on_q <= 1'b1;
                        end else begin
                            ack_on_q <= 1'b0;
                            bit_q    <= '0;
                            if (state_q == ST_ADDR_ACK) begin
                                ptr_ph_q <= !rw_q;
                                if (rw_q) sh_q <= rd_data;
                            end
                        end
                    end
                    ST_WR_BYTE: if (rise_c) begin
                        sh_q  <= sh_in;
                        bit_q <= bit_q + 3'd1;
                        if (bit_q == 3'd7) begin
                            if (ptr_ph_q) begin
                                ptr_q    <= sh_in[AW-1:0];
                                ptr_ph_q <= 1'b0;
                            end else begin
                                we    <= 1'b1;
                                waddr <= ptr_q;
                                wdata <= sh_in;
                                ptr_q <= ptr_q + AW'(1);
                            end
                        end
                    end
                    ST_RD_BYTE: if (fall_c) begin
                        if (bit_q == 3'd7) begin
                            ptr_q <= ptr_q + AW'(1);
                        end else begin
                            sh_q  <= {sh_q[6:0], 1'b0};
                            bit_q <= bit_q + 3'd1;
                        end
                    end
                    ST_RD_ACK: begin
                        if (rise_c) more_q <= !sda_f;
                        if (fall_c && more_q) begin
                            sh_q  <= rd_data;
                            bit_q <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Output decode
    always_comb begin
        sda_oe = 1'b0;
        if ((state_q == ST_ADDR_ACK || state_q == ST_WR_ACK) && ack_on_q) sda_oe = 1'b1;
        if (state_q == ST_RD_BYTE && !sh_q[7]) sda_oe = 1'b1;
    end

    // R9
    lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !pwr_done |-> !sda_oe);
    // R2
    bad_strap_chk: assert property (@(posedge clk) disable iff (!rst_n) !addr_ok |-> !sda_oe);
    // R3
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_c && state_q != ST_LOCK) |=> state_q == ST_IDLE);
    // R10
    start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_c && state_q != ST_LOCK) |=> (state_q == ST_ADDR && bit_q == 3'd0));
    // R11
    sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall_c && !start_c && !stop_c) |=> $stable(sda_oe));
endmodule

// File: rtl/strap_i2c_target.sv
module strap_i2c_target
    import i2c_tgt_pkg::*;
#(
    parameter int PWRUP_CYC = 1000000,
    parameter int REGS      = 16,
    parameter int FILT_LEN  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] strap_code,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe
);
    localparam int AW = $clog2(REGS);

    logic [1:0]    raw, filt;
    strap_addr_t   cfg;
    logic          we;
    logic [AW-1:0] waddr, raddr;
    logic [7:0]    wdata, rdata;

    assign raw = {scl_i, sda_i};
    assign cfg = strap_decode(strap_code);

    for (genvar g = 0; g < 2; g++) begin : g_line
        i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk(clk), .rst_n(rst_n), .din(raw[g]), .dout(filt[g])
        );
    end

    i2c_regfile #(.REGS(REGS), .DW(8), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(rdata)
    );

    i2c_tgt_fsm #(.PWRUP_CYC(PWRUP_CYC), .REGS(REGS), .AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_f(filt[1]), .sda_f(filt[0]),
        .dev_addr(cfg.addr), .addr_ok(cfg.ok), .rd_data(rdata),
        .we(we), .waddr(waddr), .wdata(wdata), .raddr(raddr), .sda_oe(sda_oe)
    );
endmodule

// File: tb/sim_strap_i2c_target.sv
module sim_strap_i2c_target;
    localparam int PWR = 2000;
    localparam int Q   = 10;
    // {strap code, expect ack, address tried}
    localparam logic [10:0] VEC [8] = '{
        {3'd0, 1'b0, 7'h71}, {3'd1, 1'b1, 7'h71}, {3'd2, 1'b1, 7'h72}, {3'd3, 1'b1, 7'h73},
        {3'd4, 1'b1, 7'h76}, {3'd5, 1'b0, 7'h72}, {3'd6, 1'b0, 7'h73}, {3'd7, 1'b0, 7'h76}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [2:0] strap = 3'd1;
    logic scl = 1'b1, host_low = 1'b0;
    logic sda_oe;
    wire  sda;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    assign sda = !(host_low || sda_oe);
    always #2 clk = ~clk;

    strap_i2c_target #(.PWRUP_CYC(PWR)) u0 (
        .clk(clk), .rst_n(rst_n), .strap_code(strap),
        .scl_i(scl), .sda_i(sda), .sda_oe(sda_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic i2c_start;
        if (!scl) begin host_low = 1'b0; wt(Q); scl = 1'b1; wt(Q); end
        host_low = 1'b1; wt(Q); scl = 1'b0; wt(Q);
    endtask

    task automatic i2c_stop;
        host_low = 1'b1; wt(Q); scl = 1'b1; wt(Q); host_low = 1'b0; wt(2*Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            host_low = !b[7-i]; wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0; wt(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output int ack);
        send_bits(b, 8);
        host_low = 1'b0; wt(Q); scl = 1'b1; wt(Q);
        ack = (sda == 1'b0) ? 1 : 0;
        wt(Q); scl = 1'b0; wt(Q);
    endtask

    task automatic recv_byte(input bit host_ack, output logic [7:0] d);
        host_low = 1'b0;
        for (int i = 0; i < 8; i++) begin
            wt(Q); scl = 1'b1; wt(Q); d[7-i] = sda; wt(Q); scl = 1'b0; wt(Q);
        end
        host_low = host_ack; wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0; wt(Q);
        host_low = 1'b0;
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d0,
                            input logic [7:0] d1, input int n, output int acks);
        int k;
        acks = 0;
        i2c_start;
        send_byte({a, 1'b0}, k); acks += k;
        send_byte(p, k); acks += k;
        send_byte(d0, k); acks += k;
        if (n > 1) begin send_byte(d1, k); acks += k; end
        i2c_stop;
    endtask

    task automatic do_read(input logic [6:0] a, input logic [7:0] p, input int n,
                           output logic [7:0] r0, output logic [7:0] r1, output int acks, output int rel);
        int k;
        acks = 0; r1 = '0;
        i2c_start;
        send_byte({a, 1'b0}, k); acks += k;
        send_byte(p, k); acks += k;
        i2c_start;
        send_byte({a, 1'b1}, k); acks += k;
        recv_byte(n > 1, r0);
        if (n > 1) recv_byte(1'b0, r1);
        wt(Q);
        rel = sda;
        i2c_stop;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int ack, acks, rel;
        logic [7:0] r0, r1;
        wt(5);
        chk("R11 sda_oe in reset", sda_oe, 0);
        rst_n = 1'b1;
        wt(2);
        // R9: full address byte inside the hold interval
        i2c_start;
        send_byte({7'h71, 1'b0}, ack);
        i2c_stop;
        chk("R9 no ack during power-up", ack, 0);
        wt(PWR);

        // R1 / R2 / R4 table walk
        for (int v = 0; v < 8; v++) begin
            strap = VEC[v][10:8];
            wt(5);
            i2c_start; send_byte({VEC[v][6:0], 1'b0}, ack); i2c_stop;
            chk(VEC[v][7] ? "R1 strap address ack" : "R2 invalid strap no ack", ack, int'(VEC[v][7]));
            if (VEC[v][7]) begin
                i2c_start; send_byte({VEC[v][6:0] ^ 7'h01, 1'b0}, ack); i2c_stop;
                chk("R4 wrong address nack", ack, 0);
            end
        end
        strap = 3'd1;
        wt(5);

        do_read(7'h71, 8'h02, 1, r0, r1, acks, rel);
        chk("R11 register reset value", r0, 0);

        do_write(7'h71, 8'h03, 8'hA5, 8'h00, 1, acks);
        chk("R5 write acks", acks, 3);
        do_read(7'h71, 8'h03, 1, r0, r1, acks, rel);
        chk("R3 R6 read acks", acks, 3);
        chk("R6 read data", r0, 8'hA5);

        do_write(7'h71, 8'h05, 8'h11, 8'h22, 2, acks);
        chk("R5 burst write acks", acks, 4);
        do_read(7'h71, 8'h05, 2, r0, r1, acks, rel);
        chk("R8 first byte", r0, 8'h11);
        chk("R7 second byte after host ack", r1, 8'h22);
        chk("R7 sda released after nack", rel, 1);

        do_write(7'h71, 8'h0F, 8'h5A, 8'h6B, 2, acks);
        do_read(7'h71, 8'h0F, 2, r0, r1, acks, rel);
        chk("R8 reg15", r0, 8'h5A);
        chk("R8 wrap to reg0", r1, 8'h6B);

        do_write(7'h70, 8'h03, 8'hFF, 8'hFF, 2, acks);
        chk("R4 mismatched write no acks", acks, 0);
        do_read(7'h71, 8'h03, 1, r0, r1, acks, rel);
        chk("R4 register untouched", r0, 8'hA5);

        // R10: START in the middle of the address byte
        i2c_start;
        send_bits({7'h71, 1'b0}, 4);
        do_write(7'h71, 8'h09, 8'hC3, 8'h00, 1, acks);
        chk("R10 write after mid-byte start", acks, 3);
        do_read(7'h71, 8'h09, 1, r0, r1, acks, rel);
        chk("R10 data after restart", r0, 8'hC3);

        // R10: STOP in the middle of a data byte
        i2c_start;
        send_byte({7'h71, 1'b0}, ack);
        send_byte(8'h0A, ack);
        send_bits(8'h77, 4);
        i2c_stop;
        do_read(7'h71, 8'h0A, 1, r0, r1, acks, rel);
        chk("R10 aborted byte not written", r0, 0);
        chk("R11 sda_oe idle", sda_oe, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule